// File: doc/BRIEF.md
# Partial Thread-Block Warp Launcher

This block decides when the warps of a thread block may be launched onto a streaming multiprocessor. The next thread block is offered on a request port with its ID, its warp count, its register need per warp and its shared-memory need. Free register, warp-context and shared-memory counts come in from the resource pools. Warp launch commands go out on a valid/ready port, one command per cycle. Each command names a block, a first warp index and a warp count.

When the whole block fits, a single command launches all of its warps and the block is accepted. When the whole block does not fit, the block can still start if three things hold: its shared memory fits, one warp's registers fit and one warp context is free. In that case warp 0 is launched alone, the block is accepted, and a single partial-block entry records the block ID, the register need per warp, the next unissued warp and the last warp. The block-level shared-memory check is made only at that first launch. After that, the entry is drained warp by warp, checking only registers and contexts. Once everything that remains fits, the rest goes out in one command and the entry is freed. New blocks wait until it is freed.

The resource pools sit outside this block and must reflect every launch by the cycle after its handshake.

Top module: `tbw_launcher`

## Requirements
- R1: After reset no partial block is pending, so with no block offered `lch_valid` and `blk_ready` are 0.
- R2: With no partial block pending, if the offered block's shared memory fits, its warp count does not exceed `free_ctx`, and warp count times `blk_regs` does not exceed `free_regs`, then one command goes out with `lch_blk`=block ID, `lch_first`=0 and `lch_count`=warp count. `blk_ready` is 1 in the cycle that command is accepted.
- R3: With no partial block pending, if the whole block does not fit but its shared memory fits, `free_ctx`>=1 and `blk_regs`<=`free_regs`, then a command with `lch_first`=0 and `lch_count`=1 goes out. The block is accepted when that command is accepted, and it becomes the partial block with warps 1..N-1 unissued.
- R4: An offered block whose shared memory exceeds `free_smem`, or for which one warp does not fit in registers or contexts, produces no command and is not accepted.
- R5: At most one partial block exists. While it is pending, `blk_ready` stays 0 and every command carries the partial block's ID.
- R6: Partial-block warps are issued in ascending order. `lch_first` is the lowest unissued warp, and `lch_count` is 1 when the remaining warps do not all fit in contexts and registers.
- R7: When all remaining warps of the partial block fit, one command covers them (`lch_count` = remaining count). After it is accepted, the entry is empty and new blocks are considered again.
- R8: Shared memory is not checked again for the partial block: its warps keep launching while `free_smem` is 0.
- R9: While `lch_valid`=1 and `lch_ready`=0, no block is accepted and no progress is recorded. The same command is offered on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A next thread block is offered |
| blk_ready | output | 1 | Offered block accepted this cycle |
| blk_id | input | BLK_W | Offered block ID |
| blk_nwarps | input | CNT_W | Warps in offered block (1..MAX_WARPS) |
| blk_regs | input | RPW_W | Registers needed per warp |
| blk_smem | input | SMEM_W | Shared memory needed by the block |
| free_regs | input | REG_W | Free registers in the pool |
| free_ctx | input | CTX_W | Free warp contexts |
| free_smem | input | SMEM_W | Free shared memory |
| lch_valid | output | 1 | Launch command valid |
| lch_ready | input | 1 | SM accepts the launch command |
| lch_blk | output | BLK_W | Block ID of the command |
| lch_first | output | IDX_W | First warp index launched |
| lch_count | output | CNT_W | Number of consecutive warps launched |

## Verification
The hardest state to reach is a partial block in the middle of draining while a competing new block is offered and shared memory has run out. Only in that state can the ordering rule and the single shared-memory check be seen together. The stimulus starts the partial block by offering a block whose whole register need exceeds the pool while one warp fits. It then keeps a second block offered, drops `free_smem` to zero and steps the register and context counts. This makes the entry issue single warps, stall under backpressure and finally issue the tail in one command before the waiting block is accepted.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  // Source of the command offered this cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NEW  = 2'd1,
    SRC_PART = 2'd2
  } tbw_src_e;
endpackage

// File: rtl/tbw_fit.sv
// Warp-level fit test: n warps need n contexts and n*rpw registers.
module tbw_fit #(
  parameter int CNT_W = 6,
  parameter int RPW_W = 8,
  parameter int REG_W = 16,
  parameter int CTX_W = 7
) (
  input  logic [CNT_W-1:0] nwarps,
  input  logic [RPW_W-1:0] rpw,
  input  logic [REG_W-1:0] free_regs,
  input  logic [CTX_W-1:0] free_ctx,
  output logic             fits
);
  localparam int PW = CNT_W + RPW_W;
  logic [PW-1:0] need;

  always_comb begin
    need = PW'(nwarps) * PW'(rpw);
    fits = (32'(nwarps) <= 32'(free_ctx)) && (32'(need) <= 32'(free_regs));
  end
endmodule

// File: rtl/tbw_entry.sv
// Single partial-block entry: block ID, regs per warp, next unissued warp, last warp.
module tbw_entry #(
  parameter int BLK_W = 8,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6,
  parameter int RPW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] ld_blk,
  input  logic [IDX_W-1:0] ld_last,
  input  logic [RPW_W-1:0] ld_rpw,
  input  logic             adv,
  input  logic [CNT_W-1:0] step,
  output logic             v_q,
  output logic [BLK_W-1:0] blk_q,
  output logic [IDX_W-1:0] start_q,
  output logic [RPW_W-1:0] rpw_q,
  output logic [CNT_W-1:0] rem
);
  logic [IDX_W-1:0] last_q, last_d, start_d;
  logic [BLK_W-1:0] blk_d;
  logic [RPW_W-1:0] rpw_d;
  logic             v_d, en, done;

  always_comb begin
    rem  = CNT_W'(last_q) - CNT_W'(start_q) + CNT_W'(1);
    done = (step == rem);
    en   = load | adv;
    v_d = v_q; blk_d = blk_q; start_d = start_q; last_d = last_q; rpw_d = rpw_q;
    if (load) begin
      v_d     = 1'b1;
      blk_d   = ld_blk;
      start_d = IDX_W'(1);
      last_d  = ld_last;
      rpw_d   = ld_rpw;
    end else if (adv) begin
      if (done) v_d = 1'b0;
      start_d = start_q + IDX_W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0; blk_q <= '0; start_q <= '0; last_q <= '0; rpw_q <= '0;
    end else if (en) begin
      v_q <= v_d; blk_q <= blk_d; start_q <= start_d; last_q <= last_d; rpw_q <= rpw_d;
    end
  end

  // R5: a new partial block is never captured over a pending one
  a_r5_one_partial: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !v_q);
  // R6: a partial step that does not finish moves the start index forward by the count
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !done |=> v_q && (start_q == $past(start_q) + IDX_W'($past(step))));
  // R7: issuing all remaining warps frees the entry
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adv && done |=> !v_q);
endmodule

// File: rtl/tbw_launcher.sv
module tbw_launcher
  import tbw_pkg::*;
#(
  parameter int MAX_WARPS = 32,
  parameter int BLK_W     = 8,
  parameter int RPW_W     = 8,
  parameter int REG_W     = 16,
  parameter int CTX_W     = 7,
  parameter int SMEM_W    = 16,
  localparam int IDX_W    = $clog2(MAX_WARPS),
  localparam int CNT_W    = $clog2(MAX_WARPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  blk_id,
  input  logic [CNT_W-1:0]  blk_nwarps,
  input  logic [RPW_W-1:0]  blk_regs,
  input  logic [SMEM_W-1:0] blk_smem,
  input  logic [REG_W-1:0]  free_regs,
  input  logic [CTX_W-1:0]  free_ctx,
  input  logic [SMEM_W-1:0] free_smem,
  output logic              lch_valid,
  input  logic              lch_ready,
  output logic [BLK_W-1:0]  lch_blk,
  output logic [IDX_W-1:0]  lch_first,
  output logic [CNT_W-1:0]  lch_count
);
  tbw_src_e         src;
  logic             ent_v, fit_all, fit_one, smem_ok, fire, load, adv;
  logic [BLK_W-1:0] ent_blk;
  logic [IDX_W-1:0] ent_start, ld_last;
  logic [RPW_W-1:0] ent_rpw, rpw_sel;
  logic [CNT_W-1:0] ent_rem, want_n;

  // Source selection: a pending partial block always wins
  always_comb begin
    smem_ok = (blk_smem <= free_smem);
    if (ent_v)                     src = SRC_PART;
    else if (blk_valid && smem_ok) src = SRC_NEW;
    else                           src = SRC_NONE;
    want_n  = ent_v ? ent_rem : blk_nwarps;
    rpw_sel = ent_v ? ent_rpw : blk_regs;
  end

  tbw_fit #(.CNT_W(CNT_W), .RPW_W(RPW_W), .REG_W(REG_W), .CTX_W(CTX_W)) u_fit_all (
    .nwarps(want_n), .rpw(rpw_sel), .free_regs(free_regs), .free_ctx(free_ctx),
    .fits(fit_all));

  tbw_fit #(.CNT_W(CNT_W), .RPW_W(RPW_W), .REG_W(REG_W), .CTX_W(CTX_W)) u_fit_one (
    .nwarps(CNT_W'(1)), .rpw(rpw_sel), .free_regs(free_regs), .free_ctx(free_ctx),
    .fits(fit_one));

  // Launch command and handshakes
  always_comb begin
    lch_valid = (src != SRC_NONE) && fit_one;
    lch_count = fit_all ? want_n : CNT_W'(1);
    lch_first = ent_v ? ent_start : '0;
    lch_blk   = ent_v ? ent_blk : blk_id;
    fire      = lch_valid && lch_ready;
    blk_ready = fire && (src == SRC_NEW);
    load      = blk_ready && !fit_all;
    adv       = fire && (src == SRC_PART);
    ld_last   = IDX_W'(blk_nwarps - CNT_W'(1));
  end

  tbw_entry #(.BLK_W(BLK_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .RPW_W(RPW_W)) u_entry (
    .clk(clk), .rst_n(rst_n),
    .load(load), .ld_blk(blk_id), .ld_last(ld_last), .ld_rpw(blk_regs),
    .adv(adv), .step(lch_count),
    .v_q(ent_v), .blk_q(ent_blk), .start_q(ent_start), .rpw_q(ent_rpw), .rem(ent_rem));

  // R5: while a partial block is pending no new block is taken
  a_r5_no_new_block: assert property (@(posedge clk) disable iff (!rst_n)
    ent_v |-> !blk_ready);
  // R6: a command never asks for more warp contexts than are free
  a_r6_ctx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lch_valid |-> (32'(lch_count) <= 32'(free_ctx)) && (lch_count != '0));
  // R9: a refused command leaves the partial entry unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lch_valid && !lch_ready |=> $stable(ent_v) && $stable(ent_start));
endmodule

// File: tb/tbw_launcher_test.sv
module tbw_launcher_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0, blk_ready;
  logic [7:0]  blk_id = '0;
  logic [5:0]  blk_nwarps = '0;
  logic [7:0]  blk_regs = '0;
  logic [15:0] blk_smem = '0;
  logic [15:0] free_regs = '0;
  logic [6:0]  free_ctx = '0;
  logic [15:0] free_smem = '0;
  logic        lch_valid, lch_ready = 1'b0;
  logic [7:0]  lch_blk;
  logic [4:0]  lch_first;
  logic [5:0]  lch_count;

  int n_chk = 0;
  int n_bad = 0;

  tbw_launcher uut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_id(blk_id), .blk_nwarps(blk_nwarps), .blk_regs(blk_regs), .blk_smem(blk_smem),
    .free_regs(free_regs), .free_ctx(free_ctx), .free_smem(free_smem),
    .lch_valid(lch_valid), .lch_ready(lch_ready), .lch_blk(lch_blk),
    .lch_first(lch_first), .lch_count(lch_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checks a full command: valid, block, first, count, blk_ready
  task automatic check_cmd(input string req, input int v, input int b, input int f,
                           input int c, input int r);
    check({req, " valid"}, int'(lch_valid), v);
    if (v != 0) begin
      check({req, " blk"}, int'(lch_blk), b);
      check({req, " first"}, int'(lch_first), f);
      check({req, " count"}, int'(lch_count), c);
    end
    check({req, " blk_ready"}, int'(blk_ready), r);
  endtask

  task automatic offer(input int id, input int n, input int rpw, input int sm);
    blk_valid = 1'b1; blk_id = 8'(id); blk_nwarps = 6'(n);
    blk_regs = 8'(rpw); blk_smem = 16'(sm);
  endtask

  task automatic pool(input int r, input int c, input int s);
    free_regs = 16'(r); free_ctx = 7'(c); free_smem = 16'(s);
  endtask

  task automatic t_reset_and_whole();
    @(negedge clk); #1;
    check_cmd("R1 idle", 0, 0, 0, 0, 0);
    @(negedge clk);
    pool(1000, 48, 200);
    offer(5, 4, 8, 100);
    lch_ready = 1'b0;
    #1;
    check_cmd("R9 new held", 1, 5, 0, 4, 0);
    @(negedge clk);
    lch_ready = 1'b1;
    #1;
    check_cmd("R2 whole", 1, 5, 0, 4, 1);
    @(negedge clk);
    blk_valid = 1'b0;
    #1;
    check_cmd("R2 no entry left", 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_fit();
    @(negedge clk);
    pool(1000, 48, 200);
    offer(7, 4, 8, 300);
    #1; check_cmd("R4 smem short", 0, 0, 0, 0, 0);
    @(negedge clk);
    blk_smem = 16'd50; free_ctx = 7'd0;
    #1; check_cmd("R4 no ctx", 0, 0, 0, 0, 0);
    @(negedge clk);
    free_ctx = 7'd48; free_regs = 16'd7;
    #1; check_cmd("R4 regs short", 0, 0, 0, 0, 0);
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic t_partial();
    @(negedge clk);
    lch_ready = 1'b1;
    pool(25, 48, 200);
    offer(9, 6, 10, 100);
    #1; check_cmd("R3 partial start", 1, 9, 0, 1, 1);
    @(negedge clk);
    offer(12, 2, 4, 100);
    pool(15, 48, 0);
    #1; check_cmd("R5 R8 partial first", 1, 9, 1, 1, 0);
    @(negedge clk);
    lch_ready = 1'b0;
    #1; check_cmd("R9 partial held", 1, 9, 2, 1, 0);
    @(negedge clk);
    #1; check_cmd("R9 same command", 1, 9, 2, 1, 0);
    lch_ready = 1'b1;
    @(negedge clk);
    pool(100, 2, 0);
    #1; check_cmd("R6 ctx limited", 1, 9, 3, 1, 0);
    @(negedge clk);
    pool(20, 48, 0);
    #1; check_cmd("R7 tail", 1, 9, 4, 2, 0);
    @(negedge clk);
    pool(100, 48, 200);
    #1; check_cmd("R7 entry freed", 1, 12, 0, 2, 1);
    @(negedge clk);
    blk_valid = 1'b0;
    #1; check_cmd("R7 idle after", 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_whole();
    t_no_fit();
    t_partial();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule